// File: doc/BRIEF.md
# Power Mode Control Register

This block is an 8-bit control register on a simple register bus. Software uses it to pick the operating power mode of the chip. It holds the selected mode code, which drives the power-management logic, and it keeps a transition flag that software polls to learn whether the last mode change has finished.

An accepted write does three things. It loads the new mode code, sets the transition flag, and sends a one-cycle request that carries the new code to the power-management logic. That logic answers with a one-cycle done pulse, and the pulse clears the flag.

A write is silently dropped in any of these cases:
- the external protect enable is low;
- a transition is still pending;
- a sleep entry or mode transition is in progress;
- the flash is being programmed or erased;
- the mode code is not allowed.

The register occupies one bus address, set by a parameter. Read data comes back one cycle after the read strobe.

Top module: `pwr_mode_reg`

## Requirements
- R1: After a synchronous active-low reset, the mode output is 000, the request output is low, the transition flag is 0, and a read of the register returns 0x00.
- R2: A permitted write at the register address with mode code 000 (high speed) or 010 (middle speed) in bits 2:0 drives that code on the mode output from the cycle after the write.
- R3: A write whose bits 2:0 hold any code other than 000 or 010 is discarded as a whole. The mode is kept, the flag stays as it was, and no request is issued.
- R4: A write made while the protect enable input is 0 has no effect.
- R5: An accepted write sets the transition flag, which reads back in bit 4. In the cycle after the write it also raises the request output for exactly one cycle, with the new code on the request code output.
- R6: While the transition flag is 1, writes have no effect.
- R7: A done pulse clears the transition flag in the next cycle. A done pulse that arrives while no transition is pending has no effect.
- R8: While the sleep/transition-in-progress input is 1, writes have no effect.
- R9: While the flash program/erase busy input is 1, writes have no effect.
- R10: Bit 3 and bits 7:5 always read as 0. Bit 4 is read-only. The values written to bits 7:3 are ignored, and the write is accepted or refused on bits 2:0 alone.
- R11: The register answers only at the address REG_ADDR. A read at any other address returns 0x00, and a write at any other address has no effect.
- R12: A write that repeats the current mode code counts as a rewrite. It sets the flag and issues a request.
- R13: The read data output holds the register image in the cycle after a read strobe at the register address, and is 0x00 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, registered |
| prot_en | input | 1 | Write protect enable, 1 allows writes |
| lp_busy | input | 1 | Sleep entry or mode transition in progress |
| flash_busy | input | 1 | Flash program/erase in progress |
| mode_out | output | 3 | Currently selected mode code |
| mode_req | output | 1 | One-cycle mode change request |
| mode_req_code | output | 3 | Code that goes with the request |
| mode_done | input | 1 | One-cycle completion pulse from the power logic |

## Verification
Three results are due after a stimulus, and each on a fixed cycle:
- A write driven before a rising edge shows on the mode output and the request output right after that edge. The request is gone one edge later.
- A read returns its data after the edge that samples the strobe.
- A done pulse clears the flag at the edge that samples it.

The bench drives every input on falling edges. A monitor records each read strobe at the rising edge and compares the read data at the next falling edge against the expectation that the driver queued. Port checks on the mode and request outputs are made at the falling edge that directly follows the edge doing the update. Every refused write is followed by a read-back, so the unchanged state is seen at the ports.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
    localparam int REG_W    = 8;
    localparam int MODE_W   = 3;
    localparam int FLAG_BIT = 4;

    localparam logic [MODE_W-1:0] MODE_HIGH = 3'b000;
    localparam logic [MODE_W-1:0] MODE_MID  = 3'b010;

    // Returns 1 for mode codes that software is allowed to select.
    function automatic logic mode_allowed(input logic [MODE_W-1:0] code);
        return (code == MODE_HIGH) || (code == MODE_MID);
    endfunction
endpackage

// File: rtl/pmr_wr_gate.sv
// pmr_wr_gate: decodes the address and decides whether a bus write is
// accepted. Purely combinational.
// Assumes: one-cycle write strobe; interlock inputs are already synchronous.
module pmr_wr_gate
    import pmr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              prot_en,
    input  logic              lp_busy,
    input  logic              flash_busy,
    input  logic              xfer_pending,
    output logic              addr_hit,
    output logic              wr_accept,
    output logic [MODE_W-1:0] wr_code
);
    logic interlock;

    // Address compare for the single register slot.
    always_comb addr_hit = (bus_addr == REG_ADDR);

    // Any condition that freezes the register against writes.
    always_comb interlock = !prot_en || lp_busy || flash_busy || xfer_pending;

    // Only the mode field matters; reserved and flag bits are dropped.
    always_comb wr_code = bus_wdata[MODE_W-1:0];

    // Final accept: strobe, address, no interlock, permitted code.
    always_comb wr_accept = bus_wr && addr_hit && !interlock && mode_allowed(wr_code);
endmodule

// File: rtl/pmr_mode_store.sv
// pmr_mode_store: holds the selected mode code and emits a one-cycle request
// with the new code on every accepted write.
// Assumes: wr_accept is only high for permitted codes.
module pmr_mode_store
    import pmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic [MODE_W-1:0] wr_code,
    output logic [MODE_W-1:0] mode_q,
    output logic              req_q,
    output logic [MODE_W-1:0] req_code_q
);
    // Mode register: loads on accept, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_HIGH;
        else if (wr_accept) mode_q <= wr_code;
    end

    // Request pulse: one cycle after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            req_code_q <= MODE_HIGH;
        end else begin
            req_q <= wr_accept;
            if (wr_accept) req_code_q <= wr_code;
        end
    end

    // R3: the stored code is always one of the permitted values.
    p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_allowed(mode_q));

    // R5: a request never lasts more than one cycle.
    p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R5: the request carries the code now held in the register.
    p_req_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (req_code_q == mode_q));
endmodule

// File: rtl/pmr_xfer_track.sv
// pmr_xfer_track: transition status flag. Sets on an accepted write and
// clears on a done pulse from the power-management logic.
// Assumes: wr_accept is never high while the flag is set (gated upstream).
module pmr_xfer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic mode_done,
    output logic flag_q
);
    // Flag update: a set wins over a clear; a done while idle keeps it at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                   flag_q <= 1'b0;
        else if (wr_accept)           flag_q <= 1'b1;
        else if (mode_done && flag_q) flag_q <= 1'b0;
    end

    // R5: an accepted write leaves the flag set.
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> flag_q);

    // R6: no write is accepted while a transition is pending.
    p_no_accept_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> !wr_accept);

    // R7: done clears a pending flag.
    p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && mode_done) |=> !flag_q);

    // R7: a stray done pulse while idle does not disturb the flag.
    p_idle_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !wr_accept) |=> !flag_q);
endmodule

// File: rtl/pmr_rd_port.sv
// pmr_rd_port: builds the read image and registers it on a read strobe.
// Assumes: reserved bits have no storage and read back as zero.
module pmr_rd_port
    import pmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              addr_hit,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              flag_q,
    output logic [REG_W-1:0]  rdata_q
);
    logic [REG_W-1:0] image;

    // Compose the register image: mode field at the bottom, flag at FLAG_BIT.
    always_comb begin
        image                   = '0;
        image[MODE_W-1:0]       = mode_q;
        image[FLAG_BIT]         = flag_q;
    end

    // Read data register: image on a hit, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (bus_rd && addr_hit) rdata_q <= image;
        else                         rdata_q <= '0;
    end

    // R10: the reserved bits never read back as 1.
    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_q[3] == 1'b0) && (rdata_q[7:5] == 3'b000));

    // R13: without a read strobe in the previous cycle the data is zero.
    p_rd_idle_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (rdata_q == '0));
endmodule

// File: rtl/pwr_mode_reg.sv
// pwr_mode_reg: memory-mapped power mode control register. Gates writes on
// protect, sleep, flash and pending-transition interlocks; drives the mode
// and a one-cycle request to the power logic; tracks completion.
// Assumes: single-cycle bus strobes, synchronous active-low reset.
module pwr_mode_reg
    import pmr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              prot_en,
    input  logic              lp_busy,
    input  logic              flash_busy,
    output logic [2:0]        mode_out,
    output logic              mode_req,
    output logic [2:0]        mode_req_code,
    input  logic              mode_done
);
    logic              addr_hit;
    logic              wr_accept;
    logic [MODE_W-1:0] wr_code;
    logic [MODE_W-1:0] mode_q;
    logic              flag_q;

    pmr_wr_gate #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_gate (
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .prot_en      (prot_en),
        .lp_busy      (lp_busy),
        .flash_busy   (flash_busy),
        .xfer_pending (flag_q),
        .addr_hit     (addr_hit),
        .wr_accept    (wr_accept),
        .wr_code      (wr_code)
    );

    pmr_mode_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_accept  (wr_accept),
        .wr_code    (wr_code),
        .mode_q     (mode_q),
        .req_q      (mode_req),
        .req_code_q (mode_req_code)
    );

    pmr_xfer_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .mode_done (mode_done),
        .flag_q    (flag_q)
    );

    pmr_rd_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .addr_hit (addr_hit),
        .mode_q   (mode_q),
        .flag_q   (flag_q),
        .rdata_q  (bus_rdata)
    );

    // Mode output straight from the mode register.
    always_comb mode_out = mode_q;

    // R4: writes made without protect enable leave the mode unchanged.
    p_prot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> $stable(mode_out));

    // R8: writes during sleep/transition leave the mode unchanged.
    p_lp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lp_busy |=> $stable(mode_out));

    // R9: writes during flash program/erase leave the mode unchanged.
    p_flash_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flash_busy |=> (!mode_req && $stable(mode_out)));

    // R11: a write elsewhere issues no request.
    p_other_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != REG_ADDR) |=> !mode_req);
endmodule

// File: tb/pwr_mode_reg_tb.sv
module pwr_mode_reg_tb;
    localparam logic [7:0] ADDR  = 8'h3C;
    localparam logic [7:0] OTHER = 8'h3D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       prot_en = 1'b0;
    logic       lp_busy = 1'b0;
    logic       flash_busy = 1'b0;
    logic [2:0] mode_out;
    logic       mode_req;
    logic [2:0] mode_req_code;
    logic       mode_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_at_edge = 1'b0;

    pwr_mode_reg #(.ADDR_W(8), .REG_ADDR(ADDR)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rd        (bus_rd),
        .bus_rdata     (bus_rdata),
        .prot_en       (prot_en),
        .lp_busy       (lp_busy),
        .flash_busy    (flash_busy),
        .mode_out      (mode_out),
        .mode_req      (mode_req),
        .mode_req_code (mode_req_code),
        .mode_done     (mode_done)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: note read strobes at the edge, compare at the following falling edge.
    always @(posedge clk) rd_at_edge <= bus_rd && rst_n;

    always @(negedge clk) begin
        if (rd_at_edge) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R13: read data 0x%02h with no expectation", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = addr; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_done();
        @(negedge clk);
        mode_done = 1'b1;
        @(negedge clk);
        mode_done = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 mode", {5'b0, mode_out}, 8'h00);
        check("R1 req", {7'b0, mode_req}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rst_n = 1'b1;
        do_read(ADDR, 8'h00, "R1 read after reset");
        prot_en = 1'b1;

        // Middle speed accepted; request pulse with code.
        do_write(ADDR, 8'h02);
        check("R2 mode mid", {5'b0, mode_out}, 8'h02);
        check("R5 req high", {7'b0, mode_req}, 8'h01);
        check("R5 req code", {5'b0, mode_req_code}, 8'h02);
        @(negedge clk);
        check("R5 req one cycle", {7'b0, mode_req}, 8'h00);
        do_read(ADDR, 8'h12, "R5 flag read");

        // Pending: write refused.
        do_write(ADDR, 8'h00);
        check("R6 mode held", {5'b0, mode_out}, 8'h02);
        check("R6 no req", {7'b0, mode_req}, 8'h00);
        do_read(ADDR, 8'h12, "R6 read");

        do_done();
        do_read(ADDR, 8'h02, "R7 done clears");
        do_done();
        do_read(ADDR, 8'h02, "R7 idle done ignored");

        // Prohibited code.
        do_write(ADDR, 8'h05);
        check("R3 no req", {7'b0, mode_req}, 8'h00);
        do_read(ADDR, 8'h02, "R3 read");

        prot_en = 1'b0;
        do_write(ADDR, 8'h00);
        check("R4 mode held", {5'b0, mode_out}, 8'h02);
        do_read(ADDR, 8'h02, "R4 read");
        prot_en = 1'b1;

        lp_busy = 1'b1;
        do_write(ADDR, 8'h00);
        check("R8 mode held", {5'b0, mode_out}, 8'h02);
        do_read(ADDR, 8'h02, "R8 read");
        lp_busy = 1'b0;

        flash_busy = 1'b1;
        do_write(ADDR, 8'h00);
        check("R9 mode held", {5'b0, mode_out}, 8'h02);
        do_read(ADDR, 8'h02, "R9 read");
        flash_busy = 1'b0;

        // Reserved and flag bits written as 1, same code repeated.
        do_write(ADDR, 8'hFA);
        check("R12 repeat req", {7'b0, mode_req}, 8'h01);
        check("R12 repeat code", {5'b0, mode_req_code}, 8'h02);
        do_read(ADDR, 8'h12, "R10 reserved read zero");
        do_done();

        do_write(OTHER, 8'h00);
        check("R11 other write", {5'b0, mode_out}, 8'h02);
        do_read(OTHER, 8'h00, "R11 other read");
        do_read(ADDR, 8'h02, "R11 own read");

        do_write(ADDR, 8'h00);
        check("R2 mode high", {5'b0, mode_out}, 8'h00);
        do_read(ADDR, 8'h10, "R2 high pending");
        do_done();
        do_read(ADDR, 8'h00, "R2 high done");
        @(negedge clk);
        check("R13 idle rdata", bus_rdata, 8'h00);

        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R13: actual %0d reads left expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule